// File: doc/BRIEF.md
# Converter Serial Readback Port with Busy Flag

This block is a device-side digital model of the serial output of a 14-bit sampling converter. It runs in the four-wire mode in which a select line is kept separate from the convert line. A host that is under test in an FPGA drives it as it would drive the real part. A rising convert edge, taken while select is high, captures a parallel sample word and starts a conversion timer. During the conversion the data pin floats.

If select is low when the timer runs out, the data pin is driven low. With a pull-up on the line, this high-to-low change acts as a ready interrupt. The host then clocks out the word, most significant bit first, on falling serial clock edges. The pin floats again on the 15th falling edge, or earlier if select goes high. The pin is given as a separate data bit and output enable, so that the level above can build the tri-state buffer.

All inputs are sampled on the system clock. The serial clock must therefore run well below that clock. Conversion length is counted in system clock cycles.

Top module: `sar_readback_port`

## Requirements
- R1: During and right after reset the port is idle and, with select high, the output enable (`sdo_oe`) is 0.
- R2: A rising `cnv` seen while `sdi` is 1 starts a conversion, and `sdo_oe` stays 0 for the whole conversion.
- R3: When idle, `sdo_oe` is 1 with `sdo_bit` 0 exactly when `sdi` and `cnv` are both 0, and `sdo_oe` is 0 otherwise.
- R4: A conversion lasts CONV_CYCLES clock cycles after the cycle in which the start edge is taken. If `sdi` is then 0, `sdo_oe` becomes 1 with `sdo_bit` 0, which is the busy-done indication.
- R5: Each falling `sck` edge taken while select is low presents the next result bit on `sdo_bit`, bit 13 after the first fall and bit 0 after the 14th. `sdo_oe` stays 1 for the whole readback.
- R6: The result is the `sample_in` value captured when the conversion starts. Later changes to `sample_in` have no effect on it.
- R7: The 15th falling `sck` edge of a readback ends it, and the port returns to idle (with `cnv` high, `sdo_oe` 0).
- R8: A rising `sdi` during readback ends it at once, and the port returns to idle.
- R9: Rising `cnv` edges during a conversion neither restart the conversion nor capture a new sample.
- R10: If `sdi` is 1 when the conversion ends, no busy indication is given. The result is held, and lowering `sdi` later drives the pin low and allows a full readback.
- R11: Rising `sck` edges never change `sdo_bit`.
- R12: A rising `cnv` while `sdi` is 0 does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert input; a rising edge starts a conversion |
| sdi | input | 1 | Select input, active low for readback |
| sck | input | 1 | Serial clock from the host |
| sample_in | input | DATA_W | Parallel sample value to be converted |
| sdo_bit | output | 1 | Data value for the serial output pin |
| sdo_oe | output | 1 | Drive enable for the serial output pin |

## Verification
An edge on `cnv`, `sdi` or `sck` is taken at the first clock edge that sees the new level. Its effect shows after that edge. The bench drives each input one time unit after a rising clock edge and reads the outputs one time unit after the following rising edge.

The busy indication is due exactly CONV_CYCLES edges after the start edge. The bench checks that the pin still floats one edge earlier and is driven at that edge. Each data bit is read one edge after its `sck` fall, and it is checked again one edge after the next `sck` rise to confirm that it held. The idle rule depends only on the present levels of `sdi` and `cnv`, so it is checked as soon as those inputs change.

// File: rtl/sar_readback_port.sv
module sar_readback_port #(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sdi,
  input  logic              sck,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo_bit,
  output logic              sdo_oe
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam int CW = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {IDLE, CONV, READY, SHIFT} st_t;
  st_t st;

  logic cnv_q, sdi_q, sck_q;
  logic [TW-1:0] timer;
  logic [CW-1:0] nfall;
  logic [DATA_W-1:0] sample_q, shreg;

  wire cnv_rise = cnv & ~cnv_q;
  wire sdi_rise = sdi & ~sdi_q;
  wire sck_fall = ~sck & sck_q;
  wire start    = cnv_rise & sdi & (st != CONV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnv_q <= 1'b0;
      sdi_q <= 1'b1;
      sck_q <= 1'b0;
      timer <= '0;
      nfall <= '0;
      sample_q <= '0;
      shreg <= '0;
    end else begin
      cnv_q <= cnv;
      sdi_q <= sdi;
      sck_q <= sck;
      if (start) begin
        st <= CONV;
        timer <= TW'(CONV_CYCLES - 1);
        sample_q <= sample_in;
      end else begin
        case (st)
          CONV:
            if (timer == '0) begin
              st <= READY;
              shreg <= sample_q;
            end else timer <= timer - 1'b1;
          READY:
            if (sck_fall && !sdi) begin
              st <= SHIFT;
              nfall <= CW'(1);
            end
          SHIFT:
            if (sdi_rise) st <= IDLE;
            else if (sck_fall) begin
              if (nfall == CW'(DATA_W)) st <= IDLE;
              else begin
                shreg <= shreg << 1;
                nfall <= nfall + 1'b1;
              end
            end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      IDLE:    sdo_oe = ~sdi & ~cnv;
      READY:   sdo_oe = ~sdi;
      SHIFT:   sdo_oe = 1'b1;
      default: sdo_oe = 1'b0;
    endcase
  end

  assign sdo_bit = (st == SHIFT) ? shreg[DATA_W-1] : 1'b0;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == CONV));
  assert_conv_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CONV) |-> !sdo_oe);
  assert_shift_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT) |-> sdo_oe);
  assert_last_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && sck_fall && !start && !sdi_rise && nfall == CW'(DATA_W)) |=> (st == IDLE));
  assert_sel_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && sdi_rise) |=> (st != SHIFT));
  assert_ignore_cnv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CONV && cnv_rise) |=> $stable(sample_q));
  assert_rise_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && sck && !sck_q && !sdi_rise && !start) |=> $stable(sdo_bit));
  assert_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && cnv_rise && !sdi) |=> (st == IDLE));
endmodule

// File: tb/sar_readback_port_tb.sv
module sar_readback_port_tb_top;
  localparam int DW = 14;
  localparam int N  = 20;

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sdi = 1'b1, sck = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic sdo_bit, sdo_oe;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  sar_readback_port #(.DATA_W(DW), .CONV_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sck(sck),
    .sample_in(sample_in), .sdo_bit(sdo_bit), .sdo_oe(sdo_oe));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_conv(input logic [DW-1:0] w);
    sdi = 1'b1; cnv = 1'b0; tick();
    sample_in = w; cnv = 1'b1; tick();
    sample_in = ~w;
  endtask

  task automatic read_word(output logic [DW-1:0] got, input int nbits);
    got = '0;
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b1; tick();
      if (b > 0) check(sdo_bit == got[0], "R11", sdo_bit, got[0]);
      sck = 1'b0; tick();
      got = {got[DW-2:0], sdo_bit};
    end
  endtask

  initial begin
    #2000000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] w, got;
    tick(); tick();
    check(sdo_oe == 1'b0, "R1", sdo_oe, 0);
    rst_n = 1'b1; tick();
    check(sdo_oe == 1'b0, "R1", sdo_oe, 0);
    sdi = 1'b0; tick();
    check(sdo_oe == 1'b1 && sdo_bit == 1'b0, "R3", {sdo_oe, sdo_bit}, 2);
    cnv = 1'b1; tick();
    check(sdo_oe == 1'b0, "R3", sdo_oe, 0);
    for (int k = 0; k < N + 2; k++) tick();
    check(sdo_oe == 1'b0, "R12", sdo_oe, 0);
    cnv = 1'b0; tick();
    check(sdo_oe == 1'b1, "R3", sdo_oe, 1);

    for (int i = 0; i < 48; i++) begin
      if (i < DW) w = DW'(1) << i;
      else if (i == DW) w = '1;
      else if (i == DW + 1) w = '0;
      else w = DW'(i * 1237 + 91);
      start_conv(w);
      check(sdo_oe == 1'b0, "R2", sdo_oe, 0);
      for (int k = 1; k < N; k++) begin
        if (i % 3 == 0 && k == 2) cnv = 1'b0;
        if (i % 3 == 0 && k == 3) begin cnv = 1'b1; sample_in = DW'(i); end
        if (k == 5) sdi = 1'b0;
        tick();
      end
      check(sdo_oe == 1'b0, "R2", sdo_oe, 0);
      tick();
      check(sdo_oe == 1'b1 && sdo_bit == 1'b0, "R4", {sdo_oe, sdo_bit}, 2);
      read_word(got, DW);
      check(got == w, (i % 3 == 0) ? "R9" : "R5 R6", got, w);
      check(sdo_oe == 1'b1, "R5", sdo_oe, 1);
      sck = 1'b1; tick(); sck = 1'b0; tick();
      check(sdo_oe == 1'b0, "R7", sdo_oe, 0);
    end

    start_conv(14'h2A5C);
    sdi = 1'b0;
    for (int k = 0; k < N; k++) tick();
    read_word(got, 5);
    check(got[4:0] == 5'b10101, "R5", got[4:0], 5'b10101);
    sdi = 1'b1; tick();
    check(sdo_oe == 1'b0, "R8", sdo_oe, 0);
    sdi = 1'b0; tick();
    check(sdo_oe == 1'b0, "R8", sdo_oe, 0);
    sck = 1'b1; tick(); sck = 1'b0; tick();
    check(sdo_oe == 1'b0, "R8", sdo_oe, 0);

    start_conv(14'h1337);
    for (int k = 0; k < N + 3; k++) tick();
    check(sdo_oe == 1'b0, "R10", sdo_oe, 0);
    sdi = 1'b0; tick();
    check(sdo_oe == 1'b1 && sdo_bit == 1'b0, "R10", {sdo_oe, sdo_bit}, 2);
    read_word(got, DW);
    check(got == 14'h1337, "R10", got, 14'h1337);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule